// File: doc/BRIEF.md
# Minimal 8-bit Accumulator Core

This block is a very small sequencer that steps through a byte-coded program held in an external program memory. It fetches one opcode at a time through a synchronous read port, decodes it and executes it. Three opcodes are recognised. Load-immediate (`0xA9`) places the byte that follows it into the accumulator. Transfer (`0xAA`) copies the accumulator into the index register. Stop (`0x00`) parks the core. The accumulator, the index register, the status byte and the program counter are driven straight onto output ports, so the surrounding logic can watch the results.

After reset the core waits in an idle state. A single-cycle `start` pulse rewinds the program counter to zero and begins execution. The core keeps running until it meets the stop opcode or a byte it does not recognise, and then it holds in a halted state. Another `start` pulse runs the program again from address zero. The accumulator, index and status contents carry over from the previous run.

Top module: `acc8_core`

## Requirements
- R1: On reset the accumulator, index register, status byte and program counter are all 0x00/0x0000, `halted` and `illegal` are low, and `mem_rd` stays low until a start pulse arrives.
- R2: A start pulse seen in the idle or halted state sets the program counter to 0x0000 and enters the fetch state. Every opcode is read from the address held in the program counter, and the program counter then advances by one. Program memory returns data one cycle after `mem_rd` is high.
- R3: Opcode 0xA9 reads the next byte, loads it into the accumulator and leaves the program counter just past that byte. The instruction takes 4 cycles.
- R4: Opcode 0xAA copies the accumulator into the index register and takes 3 cycles.
- R5: Opcode 0x00 enters the halted state. `halted` goes high 2 cycles after its fetch begins, `pc_q` then holds the stop address plus one, no memory reads happen, and the core stays in this state until the next start pulse. The count from the edge that samples start until halted is 1 + the sum of the instruction cycles + 2.
- R6: Status bit 1 is the zero flag. Load-immediate and transfer set it when the moved byte is 0x00 and clear it otherwise.
- R7: Status bit 7 is the negative flag. Load-immediate and transfer copy bit 7 of the moved byte into it.
- R8: No instruction changes any status bit other than bits 1 and 7, so those other bits stay 0.
- R9: Any opcode other than 0xA9, 0xAA or 0x00 halts the core with the same timing as 0x00 and raises `illegal`. The next start pulse clears `illegal`.
- R10: A start pulse that arrives while the program is running has no effect on the result or on the cycle count.
- R11: Register contents carry across runs. A new start does not clear the accumulator, the index register or the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins execution at address 0 |
| mem_rdata | input | 8 | Program memory read data, valid the cycle after `mem_rd` |
| mem_addr | output | 16 | Program memory read address |
| mem_rd | output | 1 | Program memory read enable |
| halted | output | 1 | High while the core is stopped after a run |
| illegal | output | 1 | High when the last run ended on an unrecognised opcode |
| acc_q | output | 8 | Accumulator contents |
| idx_q | output | 8 | Index register contents |
| stat_q | output | 8 | Status byte (bit 7 negative, bit 1 zero) |
| pc_q | output | 16 | Program counter |

## Verification
If the control state machine takes a wrong step, the program counter goes out of step with the opcode stream. The error then shows in the final `pc_q` and in the number of cycles to `halted`, both within the run in which it happens. A wrong flag or a wrong register write shows on `stat_q`, `acc_q` or `idx_q` one cycle after the write cycle. The bench compares every run against a model that walks the same program bytes, and it checks all three registers and the cycle count after each run. An error that comes from carried-over state appears on the following run, which starts from the registers the previous run left behind.

// File: rtl/acc8_pkg.sv
package acc8_pkg;

    localparam int DATA_W = 8;
    localparam int ZERO_BIT = 1;
    localparam int NEG_BIT  = 7;

    typedef logic [DATA_W-1:0] byte_t;

    localparam byte_t OP_LDI = 8'hA9;
    localparam byte_t OP_TAX = 8'hAA;
    localparam byte_t OP_STP = 8'h00;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DECODE,
        ST_OPERAND,
        ST_EXEC,
        ST_HALT
    } state_t;

    typedef enum logic [1:0] {
        K_LDI,
        K_TAX,
        K_STP,
        K_BAD
    } kind_t;

    typedef struct packed {
        logic  wr_acc;
        logic  wr_idx;
        byte_t val;
    } wb_t;

    function automatic kind_t classify(input byte_t op);
        case (op)
            OP_LDI:  classify = K_LDI;
            OP_TAX:  classify = K_TAX;
            OP_STP:  classify = K_STP;
            default: classify = K_BAD;
        endcase
    endfunction

    function automatic byte_t flag_merge(input byte_t p, input byte_t v);
        byte_t r;
        r = p;
        r[ZERO_BIT] = (v == '0);
        r[NEG_BIT]  = v[DATA_W-1];
        return r;
    endfunction

endpackage

// File: rtl/acc8_ctrl.sv
module acc8_ctrl
    import acc8_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  byte_t             mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] pc_q,
    output logic              halted,
    output logic              illegal,
    output wb_t               wb
);

    state_t st;
    kind_t  cur_kind;
    kind_t  op_kind;
    byte_t  opnd;

    assign cur_kind = classify(mem_rdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            pc_q    <= '0;
            op_kind <= K_STP;
            opnd    <= '0;
            illegal <= 1'b0;
        end else begin
            case (st)
                ST_IDLE, ST_HALT: begin
                    if (start) begin
                        st      <= ST_FETCH;
                        pc_q    <= '0;
                        illegal <= 1'b0;
                    end
                end
                ST_FETCH: begin
                    pc_q <= pc_q + 1'b1;
                    st   <= ST_DECODE;
                end
                ST_DECODE: begin
                    op_kind <= cur_kind;
                    case (cur_kind)
                        K_LDI: begin
                            pc_q <= pc_q + 1'b1;
                            st   <= ST_OPERAND;
                        end
                        K_TAX:   st <= ST_EXEC;
                        K_STP:   st <= ST_HALT;
                        default: begin
                            st      <= ST_HALT;
                            illegal <= 1'b1;
                        end
                    endcase
                end
                ST_OPERAND: begin
                    opnd <= mem_rdata;
                    st   <= ST_EXEC;
                end
                ST_EXEC: st <= ST_FETCH;
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_addr = pc_q;
        mem_rd   = (st == ST_FETCH) || (st == ST_DECODE && cur_kind == K_LDI);
        halted   = (st == ST_HALT);
        wb.wr_acc = (st == ST_EXEC) && (op_kind == K_LDI);
        wb.wr_idx = (st == ST_EXEC) && (op_kind == K_TAX);
        wb.val    = opnd;
    end

    p_start_rewinds_r2: assert property (@(posedge clk) disable iff (rst)
        ((st == ST_IDLE || st == ST_HALT) && start) |=> (pc_q == '0 && mem_rd));

    p_fetch_step_r2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_FETCH) |=> (pc_q == $past(pc_q) + 1'b1));

    p_ldi_skip_r3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DECODE && mem_rdata == OP_LDI) |=> (pc_q == $past(pc_q) + 1'b1));

    p_halt_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (halted && !start) |=> (halted && $stable(pc_q)));

    p_halt_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        halted |-> !mem_rd);

    p_illegal_halts_r9: assert property (@(posedge clk) disable iff (rst)
        illegal |-> halted);

    p_busy_ignores_start_r10: assert property (@(posedge clk) disable iff (rst)
        (st == ST_EXEC && start) |=> (st == ST_FETCH));

endmodule

// File: rtl/acc8_regfile.sv
module acc8_regfile
    import acc8_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  wb_t   wb,
    output byte_t acc_q,
    output byte_t idx_q,
    output byte_t stat_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            idx_q  <= '0;
            stat_q <= '0;
        end else if (wb.wr_acc) begin
            acc_q  <= wb.val;
            stat_q <= flag_merge(stat_q, wb.val);
        end else if (wb.wr_idx) begin
            idx_q  <= acc_q;
            stat_q <= flag_merge(stat_q, acc_q);
        end
    end

    p_tax_copy_r4: assert property (@(posedge clk) disable iff (rst)
        wb.wr_idx |=> (idx_q == $past(acc_q)));

    p_zero_acc_r6: assert property (@(posedge clk) disable iff (rst)
        wb.wr_acc |=> (stat_q[ZERO_BIT] == (acc_q == '0)));

    p_zero_idx_r6: assert property (@(posedge clk) disable iff (rst)
        wb.wr_idx |=> (stat_q[ZERO_BIT] == (idx_q == '0)));

    p_neg_acc_r7: assert property (@(posedge clk) disable iff (rst)
        wb.wr_acc |=> (stat_q[NEG_BIT] == acc_q[DATA_W-1]));

    p_neg_idx_r7: assert property (@(posedge clk) disable iff (rst)
        wb.wr_idx |=> (stat_q[NEG_BIT] == idx_q[DATA_W-1]));

    p_other_bits_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat_q & 8'h7D) == ($past(stat_q) & 8'h7D)));

endmodule

// File: rtl/acc8_core.sv
module acc8_core
    import acc8_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [7:0]        mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              halted,
    output logic              illegal,
    output logic [7:0]        acc_q,
    output logic [7:0]        idx_q,
    output logic [7:0]        stat_q,
    output logic [ADDR_W-1:0] pc_q
);

    wb_t wb;

    acc8_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .pc_q      (pc_q),
        .halted    (halted),
        .illegal   (illegal),
        .wb        (wb)
    );

    acc8_regfile u_regs (
        .clk    (clk),
        .rst    (rst),
        .wb     (wb),
        .acc_q  (acc_q),
        .idx_q  (idx_q),
        .stat_q (stat_q)
    );

    p_reset_idle_r1: assert property (@(posedge clk)
        $past(rst) |-> (!mem_rd && !halted && pc_q == '0 && acc_q == '0));

endmodule

// File: tb/sim_acc8_core.sv
module sim_acc8_core;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [7:0]  mem_rdata;
    logic [15:0] mem_addr;
    logic        mem_rd;
    logic        halted, illegal;
    logic [7:0]  acc_q, idx_q, stat_q;
    logic [15:0] pc_q;

    logic [7:0] mem [0:255];

    int total = 0;
    int bad   = 0;

    logic [7:0] e_a, e_x, e_p;
    int e_pc, e_ill, e_cyc;

    always #5 clk = ~clk;

    acc8_core u0 (
        .clk(clk), .rst(rst), .start(start), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .halted(halted), .illegal(illegal),
        .acc_q(acc_q), .idx_q(idx_q), .stat_q(stat_q), .pc_q(pc_q)
    );

    always_ff @(posedge clk)
        if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] flags(input logic [7:0] p, input logic [7:0] v);
        logic [7:0] r;
        r = p;
        r[1] = (v == 8'h00);
        r[7] = v[7];
        return r;
    endfunction

    task automatic model();
        int pc;
        logic [7:0] op;
        pc = 0;
        e_cyc = 1;
        e_ill = 0;
        forever begin
            op = mem[pc];
            pc++;
            if (op == 8'hA9) begin
                e_a = mem[pc];
                pc++;
                e_p = flags(e_p, e_a);
                e_cyc += 4;
            end else if (op == 8'hAA) begin
                e_x = e_a;
                e_p = flags(e_p, e_a);
                e_cyc += 3;
            end else begin
                e_cyc += 2;
                e_ill = (op != 8'h00) ? 1 : 0;
                break;
            end
        end
        e_pc = pc;
    endtask

    task automatic run(input int pulse_at);
        int n;
        model();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        n = 1;
        while (!halted && n < 5000) begin
            start = (n == pulse_at);
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        check("R5", "cycles to halt", n, e_cyc);
        check("R3", "accumulator", acc_q, e_a);
        check("R4", "index", idx_q, e_x);
        check("R6", "zero flag", stat_q[1], e_p[1]);
        check("R7", "negative flag", stat_q[7], e_p[7]);
        check("R8", "other status bits", stat_q & 8'h7D, 0);
        check("R2", "final pc", pc_q, e_pc);
        check("R9", "illegal", illegal, e_ill);
        check("R5", "no read while halted", mem_rd, 0);
        @(negedge clk);
        check("R5", "halt held", halted, 1);
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    endtask

    task automatic rand_prog();
        int p, n, r;
        logic [7:0] t;
        clear_mem();
        p = 0;
        n = 1 + ($urandom % 20);
        for (int i = 0; i < n; i++) begin
            if ($urandom % 3 != 0) begin
                r = $urandom % 8;
                mem[p] = 8'hA9;
                mem[p+1] = (r == 0) ? 8'h00 : (r == 1) ? 8'h80 : 8'($urandom);
                p += 2;
            end else begin
                mem[p] = 8'hAA;
                p += 1;
            end
        end
        if ($urandom % 4 == 0) begin
            do t = 8'($urandom); while (t == 8'h00 || t == 8'hA9 || t == 8'hAA);
            mem[p] = t;
        end else mem[p] = 8'h00;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=halt");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        clear_mem();
        rst = 1'b1;
        start = 1'b0;
        e_a = 0; e_x = 0; e_p = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        // R1: reset state and idle until start
        check("R1", "acc after reset", acc_q, 0);
        check("R1", "idx after reset", idx_q, 0);
        check("R1", "status after reset", stat_q, 0);
        check("R1", "pc after reset", pc_q, 0);
        check("R1", "halted after reset", halted, 0);
        check("R1", "illegal after reset", illegal, 0);
        check("R1", "no read before start", mem_rd, 0);

        // R3 load of a plain positive value
        mem[0] = 8'hA9; mem[1] = 8'h05; mem[2] = 8'h00;
        run(0);
        // R6 zero load
        clear_mem();
        mem[0] = 8'hA9; mem[1] = 8'h00; mem[2] = 8'h00;
        run(0);
        // R11 carried accumulator zero into index
        clear_mem();
        mem[0] = 8'hAA;
        run(0);
        check("R11", "index from previous run", idx_q, 0);
        // R7 negative load then transfer
        clear_mem();
        mem[0] = 8'hA9; mem[1] = 8'h80; mem[2] = 8'hAA; mem[3] = 8'h00;
        run(0);
        // R9 illegal opcode, then cleared by next run
        clear_mem();
        mem[0] = 8'hFF;
        run(0);
        clear_mem();
        run(0);
        check("R9", "illegal cleared", illegal, 0);
        // R10 start pulses while running
        clear_mem();
        mem[0] = 8'hA9; mem[1] = 8'h7F; mem[2] = 8'hAA; mem[3] = 8'hA9; mem[4] = 8'h01; mem[5] = 8'h00;
        run(2);
        run(7);
        run(9);

        for (int k = 0; k < 60; k++) begin
            rand_prog();
            run(($urandom % 2 == 0) ? 3 : 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule